// File: doc/BRIEF.md
# Priority-Ordered Layer Compositor

The compositor merges up to five pixel layers (four on the standard-definition instance) into a single display stream. Each layer comes from one of seven fixed sources: primary main video, alternate main video, standard-definition video, picture-in-picture video and three graphics planes. Software writes a staging set of registers: the enable mask, a priority list, a background colour and the scan-format settings. A commit write checks the set as a whole. A set that passes becomes pending and is installed at the next frame-start marker on the inputs. A set that fails is flagged and dropped.

For each output pixel, the block waits until every enabled source presents valid data. It then takes all of those pixels in the same cycle. Starting from the background colour, it blends them from the lowest-priority slot to the highest, using the alpha carried with each pixel. The result goes into an internal dual-clock FIFO. The display encoder drains that FIFO with its own clock and reset.

Top module: `layer_compositor`

## Requirements
- R1: Source eligibility is fixed by `INST_ID`. Sources are numbered 0 = primary main, 1 = alternate main, 2 = SD video, 3 = picture-in-picture, 4..6 = graphics. The eligible sets are: instances 0 and 2 take sources {0,3,4,5,6}, instance 1 takes {1,3,4,5,6}, and instance 3 takes {2,4,5,6}. A commit that enables an ineligible source sets `cfg_err_o[1]`.
- R2: Register 1 holds the priority list. Slot k sits in bits [3k+2:3k], and slot 0 is the lowest priority. For n enabled layers, slots 0..n-1 must name each enabled source exactly once. Any other list sets `cfg_err_o[0]`.
- R3: A commit that enables more layers than the instance limit sets `cfg_err_o[2]`. The limit is 5, or 4 on instance 3.
- R4: Register 3 bits [6:0] mark a source as interlaced, and bits [14:8] route that source through the interlaced path. An enabled graphics source (4..6) that has both bits set makes the commit set `cfg_err_o[3]`. An interlaced source on the progressive path is legal.
- R5: A write to register 4 commits the staged registers 0..3. `cfg_err_o` shows the flags of the latest commit one cycle later. A flagged commit changes neither the pending nor the active settings.
- R6: A pixel is 32 bits: alpha [31:24], R [23:16], G [15:8], B [7:0]. Register 2 holds the background as {R,G,B}. Each slot, in order from slot 0, updates every component as out = (a·fg + (255−a)·acc + 128) >> 8. The accumulator starts at the background colour.
- R7: A pixel is taken only when every enabled source is valid and the FIFO is not full. In that cycle `src_ready_o` equals the enable mask. In every other cycle it is zero.
- R8: A committed set stays pending until a valid enabled source shows `src_sof_i`. The block then spends one stalled cycle installing the set, and the marked pixel is composed with the new settings. When no layer is active, the set is installed at once.
- R9: The encoder receives the composed pixels in order. Data requested with `enc_rd_i` while `enc_empty_o` is low appears on `enc_pix_o` with `enc_valid_o` high in the next encoder cycle.
- R10: With the encoder idle, the block accepts exactly 2^`FIFO_AW` pixels (16 by default) and then holds ready low.
- R11: A read while `enc_empty_o` is high sets `enc_underflow_o`, which stays set until encoder reset.
- R12: After reset, `src_ready_o` and `cfg_err_o` are zero, no layer is active, and `enc_empty_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Compositor clock |
| rst_ni | input | 1 | Active-low async reset, compositor domain |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Register select: 0 enable, 1 priority, 2 background, 3 format, 4 commit |
| cfg_wdata_i | input | 24 | Configuration write data |
| cfg_err_o | output | 4 | Flags of last commit: [0] priority, [1] eligibility, [2] limit, [3] interlaced graphics |
| src_valid_i | input | 7 | Per-source pixel valid |
| src_sof_i | input | 7 | Per-source frame-start marker |
| src_pix_i | input | 224 | Seven 32-bit pixels, source i at bits [32i+31:32i] |
| src_ready_o | output | 7 | Per-source ready |
| enc_clk_i | input | 1 | Encoder pixel clock |
| enc_rst_ni | input | 1 | Active-low async reset, encoder domain |
| enc_rd_i | input | 1 | Encoder read request |
| enc_pix_o | output | 24 | Composed {R,G,B} pixel |
| enc_valid_o | output | 1 | `enc_pix_o` holds data read in the previous cycle |
| enc_empty_o | output | 1 | FIFO empty, encoder domain |
| enc_underflow_o | output | 1 | Sticky read-while-empty flag |

## Verification
The blend is tested in several ways:
- Random pixels, with alpha forced to 0 or 255 about half the time, separate the pass-through and opaque cases from the rounded middle values.
- Three-layer, five-layer and single-layer sets with shuffled priority lists show whether slot order is honoured rather than source number.
- Random per-source valid timing shows whether the block waits for the last enabled source.

The set-switching cases cover the following:
- A set is committed and then unmarked pixels are streamed. Any early switch shows up as a wrong blend.
- Each illegal set is committed alone, and streaming continues afterwards, so each flag is tested on its own and leakage into the active state can be seen.
- A fill with the encoder idle, followed by a drain, checks that exactly one FIFO depth is accepted and that order is kept.

// File: rtl/comp_pkg.sv
package comp_pkg;
  localparam int NUM_SRC = 7;
  localparam int SRC_W   = 3;
  localparam int PIX_W   = 32;
  localparam int RGB_W   = 24;
  localparam int ERR_W   = 4;

  localparam logic [NUM_SRC-1:0] GRPX_MASK = 7'b111_0000;

  typedef enum logic [2:0] {
    REG_ENABLE = 3'd0,
    REG_PRIO   = 3'd1,
    REG_BG     = 3'd2,
    REG_FORMAT = 3'd3,
    REG_COMMIT = 3'd4
  } cfg_reg_e;

  function automatic logic [NUM_SRC-1:0] eligible_mask(input int inst);
    case (inst)
      1:       return 7'b111_1010;
      3:       return 7'b111_0100;
      default: return 7'b111_1001;
    endcase
  endfunction

  function automatic int layer_limit(input int inst);
    return (inst == 3) ? 4 : 5;
  endfunction

  function automatic logic [7:0] mix_chan(input logic [7:0] a, input logic [7:0] fg,
                                          input logic [7:0] bg);
    logic [15:0] s;
    s = {8'd0, a} * {8'd0, fg} + {8'd0, 8'd255 - a} * {8'd0, bg} + 16'd128;
    return s[15:8];
  endfunction
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import comp_pkg::*;
#(
  parameter int INST_ID = 0,
  parameter int MAX_L   = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [2:0]                    addr_i,
  input  logic [RGB_W-1:0]              wdata_i,
  input  logic                          frame_start_i,
  output logic                          swap_o,
  output logic [NUM_SRC-1:0]            act_en_o,
  output logic [MAX_L-1:0][SRC_W-1:0]   act_pri_o,
  output logic [RGB_W-1:0]              act_bg_o,
  output logic [2:0]                    act_n_o,
  output logic [ERR_W-1:0]              err_o
);
  localparam logic [NUM_SRC-1:0] ELIG = eligible_mask(INST_ID);

  typedef struct packed {
    logic [NUM_SRC-1:0]          en;
    logic [MAX_L-1:0][SRC_W-1:0] pri;
    logic [RGB_W-1:0]            bg;
    logic [2:0]                  n;
  } cfg_set_t;

  cfg_set_t           st_q, pend_q, act_q;
  logic               pend_v_q;
  logic [NUM_SRC-1:0] st_il_q, st_ip_q;
  logic [ERR_W-1:0]   err_q;

  logic               commit;
  logic               bad_perm, inelig, over, il_bad;
  logic [2:0]         n_st;
  logic [ERR_W-1:0]   flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= '0;
      st_il_q <= '0;
      st_ip_q <= '0;
    end else if (we_i) begin
      case (cfg_reg_e'(addr_i))
        REG_ENABLE: st_q.en <= wdata_i[NUM_SRC-1:0];
        REG_PRIO:
          for (int k = 0; k < MAX_L; k++) st_q.pri[k] <= wdata_i[SRC_W*k +: SRC_W];
        REG_BG:     st_q.bg <= wdata_i;
        REG_FORMAT: begin
          st_il_q <= wdata_i[NUM_SRC-1:0];
          st_ip_q <= wdata_i[8 +: NUM_SRC];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    n_st     = 3'($countones(st_q.en));
    bad_perm = 1'b0;
    for (int k = 0; k < MAX_L; k++) begin
      if (k < int'(n_st)) begin
        if (st_q.pri[k] == 3'd7)          bad_perm = 1'b1;
        else if (!st_q.en[st_q.pri[k]])   bad_perm = 1'b1;
        for (int j = 0; j < k; j++)
          if (st_q.pri[j] == st_q.pri[k]) bad_perm = 1'b1;
      end
    end
    inelig = |(st_q.en & ~ELIG);
    over   = int'(n_st) > MAX_L;
    il_bad = |(st_q.en & st_il_q & st_ip_q & GRPX_MASK);
    flags  = {il_bad, over, inelig, bad_perm};
  end

  assign commit = we_i && (cfg_reg_e'(addr_i) == REG_COMMIT);
  assign swap_o = pend_v_q && (frame_start_i || (act_q.n == 3'd0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      act_q    <= '0;
      err_q    <= '0;
    end else begin
      if (swap_o) begin
        act_q    <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (commit) begin
        err_q <= flags;
        if (flags == '0) begin
          pend_q   <= '{en: st_q.en, pri: st_q.pri, bg: st_q.bg, n: n_st};
          pend_v_q <= 1'b1;
        end
      end
    end
  end

  assign act_en_o  = act_q.en;
  assign act_pri_o = act_q.pri;
  assign act_bg_o  = act_q.bg;
  assign act_n_o   = act_q.n;
  assign err_o     = err_q;

  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_o |=> $stable(act_q));

  // R5
  reject_keeps_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && (flags != '0) && !swap_o) |=> $stable(pend_q) && $stable(pend_v_q));
endmodule

// File: rtl/blend_cascade.sv
module blend_cascade
  import comp_pkg::*;
#(
  parameter int MAX_L = 5
) (
  input  logic [NUM_SRC-1:0][PIX_W-1:0] src_pix_i,
  input  logic [MAX_L-1:0][SRC_W-1:0]   pri_i,
  input  logic [2:0]                    n_i,
  input  logic [RGB_W-1:0]              bg_i,
  output logic [RGB_W-1:0]              rgb_o
);
  logic [MAX_L:0][RGB_W-1:0] acc;

  assign acc[0] = bg_i;

  for (genvar k = 0; k < MAX_L; k++) begin : g_stage
    logic [PIX_W-1:0] fg;
    logic [RGB_W-1:0] mixed;
    assign fg = (pri_i[k] < SRC_W'(NUM_SRC)) ? src_pix_i[pri_i[k]] : '0;
    for (genvar c = 0; c < 3; c++) begin : g_chan
      assign mixed[8*c +: 8] = mix_chan(fg[31:24], fg[8*c +: 8], acc[k][8*c +: 8]);
    end
    assign acc[k+1] = (3'(k) < n_i) ? mixed : acc[k];
  end

  assign rgb_o = acc[MAX_L];
endmodule

// File: rtl/cdc_pixel_fifo.sv
module cdc_pixel_fifo #(
  parameter int DW = 24,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          full_o,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          re_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          empty_o,
  output logic          underflow_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wbin_q, wgray_q, rbin_q, rgray_q;
  logic [AW:0]   wq1_q, wq2_q, rq1_q, rq2_q;
  logic [AW:0]   wbin_nx, rbin_nx;
  logic          wr_ok, rd_ok;

  assign full_o  = (wgray_q == {~rq2_q[AW:AW-1], rq2_q[AW-2:0]});
  assign empty_o = (rgray_q == wq2_q);
  assign wr_ok   = we_i && !full_o;
  assign rd_ok   = re_i && !empty_o;
  assign wbin_nx = wbin_q + 1'b1;
  assign rbin_nx = rbin_q + 1'b1;

  always_ff @(posedge wclk_i) begin
    if (wr_ok) mem_q[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rq1_q   <= '0;
      rq2_q   <= '0;
    end else begin
      rq1_q <= rgray_q;
      rq2_q <= rq1_q;
      if (wr_ok) begin
        wbin_q  <= wbin_nx;
        wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rbin_q      <= '0;
      rgray_q     <= '0;
      wq1_q       <= '0;
      wq2_q       <= '0;
      rdata_o     <= '0;
      rvalid_o    <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      wq1_q    <= wgray_q;
      wq2_q    <= wq1_q;
      rvalid_o <= rd_ok;
      if (rd_ok) begin
        rdata_o <= mem_q[rbin_q[AW-1:0]];
        rbin_q  <= rbin_nx;
        rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (re_i && empty_o) underflow_o <= 1'b1;
    end
  end

  // R10
  no_write_when_full_chk: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    full_o |=> $stable(wbin_q));

  // R11
  underflow_sticky_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    underflow_o |=> underflow_o);

  // R9
  empty_read_idle_chk: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (re_i && empty_o) |=> $stable(rbin_q) && !rvalid_o);
endmodule

// File: rtl/layer_compositor.sv
module layer_compositor
  import comp_pkg::*;
#(
  parameter int INST_ID = 0,
  parameter int FIFO_AW = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [2:0]                 cfg_addr_i,
  input  logic [RGB_W-1:0]           cfg_wdata_i,
  output logic [ERR_W-1:0]           cfg_err_o,
  input  logic [NUM_SRC-1:0]         src_valid_i,
  input  logic [NUM_SRC-1:0]         src_sof_i,
  input  logic [NUM_SRC*PIX_W-1:0]   src_pix_i,
  output logic [NUM_SRC-1:0]         src_ready_o,
  input  logic                       enc_clk_i,
  input  logic                       enc_rst_ni,
  input  logic                       enc_rd_i,
  output logic [RGB_W-1:0]           enc_pix_o,
  output logic                       enc_valid_o,
  output logic                       enc_empty_o,
  output logic                       enc_underflow_o
);
  localparam int MAX_L = layer_limit(INST_ID);

  logic [NUM_SRC-1:0]            act_en;
  logic [MAX_L-1:0][SRC_W-1:0]   act_pri;
  logic [RGB_W-1:0]              act_bg, rgb;
  logic [2:0]                    act_n;
  logic                          swap, frame_start, all_valid, fire, wfull;
  logic [NUM_SRC-1:0][PIX_W-1:0] pix;

  assign pix         = src_pix_i;
  assign all_valid   = &(src_valid_i | ~act_en);
  assign frame_start = |(src_valid_i & src_sof_i & act_en);
  assign fire        = (act_n != 3'd0) && all_valid && !wfull && !swap;
  assign src_ready_o = fire ? act_en : '0;

  cfg_regs #(.INST_ID(INST_ID), .MAX_L(MAX_L)) u_cfg (
    .clk_i, .rst_ni,
    .we_i          (cfg_we_i),
    .addr_i        (cfg_addr_i),
    .wdata_i       (cfg_wdata_i),
    .frame_start_i (frame_start),
    .swap_o        (swap),
    .act_en_o      (act_en),
    .act_pri_o     (act_pri),
    .act_bg_o      (act_bg),
    .act_n_o       (act_n),
    .err_o         (cfg_err_o)
  );

  blend_cascade #(.MAX_L(MAX_L)) u_blend (
    .src_pix_i (pix),
    .pri_i     (act_pri),
    .n_i       (act_n),
    .bg_i      (act_bg),
    .rgb_o     (rgb)
  );

  cdc_pixel_fifo #(.DW(RGB_W), .AW(FIFO_AW)) u_fifo (
    .wclk_i      (clk_i),
    .wrst_ni     (rst_ni),
    .we_i        (fire),
    .wdata_i     (rgb),
    .full_o      (wfull),
    .rclk_i      (enc_clk_i),
    .rrst_ni     (enc_rst_ni),
    .re_i        (enc_rd_i),
    .rdata_o     (enc_pix_o),
    .rvalid_o    (enc_valid_o),
    .empty_o     (enc_empty_o),
    .underflow_o (enc_underflow_o)
  );

  // R7
  ready_all_or_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_ready_o) |-> (src_ready_o == act_en) && ((src_valid_i & act_en) == act_en));

  // R8
  no_take_on_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |-> (src_ready_o == '0));
endmodule

// File: tb/layer_compositor_bench.sv
module layer_compositor_bench;
  localparam int CLK_NS = 10;
  localparam int ENC_NS = 14;
  localparam int DEPTH  = 16;

  logic        clk = 0, enc_clk = 0, rst_n = 0, enc_rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [23:0] cfg_wdata = 0;
  logic [3:0]  cfg_err;
  logic [6:0]  src_valid = 0, src_sof = 0, src_ready;
  logic [31:0] pix [7];
  logic [223:0] src_pix;
  logic        enc_rd = 0;
  logic [23:0] enc_pix;
  logic        enc_valid, enc_empty, enc_uf;

  always #(CLK_NS/2) clk = ~clk;
  always #(ENC_NS/2) enc_clk = ~enc_clk;

  always_comb for (int i = 0; i < 7; i++) src_pix[32*i +: 32] = pix[i];

  layer_compositor #(.INST_ID(0), .FIFO_AW(4)) u_layer_compositor (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_err_o(cfg_err), .src_valid_i(src_valid),
    .src_sof_i(src_sof), .src_pix_i(src_pix), .src_ready_o(src_ready),
    .enc_clk_i(enc_clk), .enc_rst_ni(enc_rst_n), .enc_rd_i(enc_rd),
    .enc_pix_o(enc_pix), .enc_valid_o(enc_valid), .enc_empty_o(enc_empty),
    .enc_underflow_o(enc_uf)
  );

  int n_chk = 0, n_bad = 0;
  logic [23:0] exp_q[$];
  bit reader_on = 0, force_rd = 0, chk_next = 0;

  // bench model of settings
  logic [6:0]  m_en = 0, p_en = 0;
  logic [2:0]  m_pri [5], p_pri [5];
  int          m_n = 0, p_n = 0;
  logic [23:0] m_bg = 0, p_bg = 0;
  bit          p_v = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FIFO-bench FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mix(input logic [7:0] a, f, b);
    int s;
    s = int'(a) * int'(f) + (255 - int'(a)) * int'(b) + 128;
    return 8'(s >> 8);
  endfunction

  function automatic logic [23:0] model_pixel();
    logic [23:0] acc;
    logic [31:0] p;
    acc = m_bg;
    for (int k = 0; k < m_n; k++) begin
      p = pix[m_pri[k]];
      for (int c = 0; c < 3; c++) acc[8*c +: 8] = mix(p[31:24], p[8*c +: 8], acc[8*c +: 8]);
    end
    return acc;
  endfunction

  always @(negedge enc_clk) begin
    if (chk_next) begin
      chk_next = 0;
      if (exp_q.size() == 0) check(0, "R9 unexpected data", {8'd0, enc_pix}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        check(enc_valid && enc_pix == e, "R6/R9 composed pixel", {7'd0, enc_valid, enc_pix}, {8'h01, e});
      end
    end
    enc_rd = 0;
    if (force_rd) begin enc_rd = 1; force_rd = 0; end
    else if (reader_on && !enc_empty) begin enc_rd = 1; chk_next = 1; end
  end

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic configure(input logic [6:0] en, input logic [2:0] pr [5], input logic [23:0] bg,
                           input logic [23:0] fmt, input logic [3:0] exp_err, input string req);
    logic [23:0] pw;
    pw = 0;
    for (int k = 0; k < 5; k++) pw[3*k +: 3] = pr[k];
    wr(0, {17'd0, en}); wr(1, pw); wr(2, bg); wr(3, fmt); wr(4, 0);
    check(cfg_err == exp_err, req, {28'd0, cfg_err}, {28'd0, exp_err});
    if (exp_err == 0) begin
      p_en = en; p_bg = bg; p_n = $countones(en); p_v = 1;
      for (int k = 0; k < 5; k++) p_pri[k] = pr[k];
    end
  endtask

  task automatic new_stim(input bit sof);
    for (int i = 0; i < 7; i++) begin
      logic [31:0] r;
      r = $urandom;
      case ($urandom % 4)
        0: r[31:24] = 8'h00;
        1: r[31:24] = 8'hff;
        default: ;
      endcase
      pix[i] = r;
    end
    src_valid = 7'($urandom) | 7'($urandom);
    src_sof   = sof ? 7'h7f : 7'h00;
  endtask

  task automatic run_pixels(input int n, input bit sof, input int max_cyc, output int got);
    bit take;
    int cyc;
    got = 0; take = 1; cyc = 0;
    while (got < n && cyc < max_cyc) begin
      @(negedge clk);
      if (take) new_stim(sof && got == 0);
      else src_valid = src_valid | 7'($urandom);
      take = 0;
      #1;
      if (|src_ready) begin
        if (p_v && (m_n == 0 || (sof && got == 0))) begin
          m_en = p_en; m_bg = p_bg; m_n = p_n; p_v = 0;
          for (int k = 0; k < 5; k++) m_pri[k] = p_pri[k];
        end
        check(src_ready == m_en && (src_valid & m_en) == m_en, "R7 ready mask",
              {25'd0, src_ready}, {25'd0, m_en});
        exp_q.push_back(model_pixel());
        got++;
        take = 1;
      end
      cyc++;
    end
    @(negedge clk); src_valid = 0; src_sof = 0;
  endtask

  task automatic drain();
    int t;
    t = 0;
    reader_on = 1;
    while ((exp_q.size() != 0 || chk_next) && t < 5000) begin @(negedge enc_clk); t++; end
    check(exp_q.size() == 0, "R9 drain", exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2:0] pa [5], pb [5], px [5];
    int got;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 7; i++) pix[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; enc_rst_n = 1;
    @(negedge clk); #1;
    // R12
    check(src_ready == 0, "R12 ready after reset", {25'd0, src_ready}, 0);
    check(cfg_err == 0, "R12 err after reset", {28'd0, cfg_err}, 0);
    check(enc_empty == 1, "R12 empty after reset", {31'd0, enc_empty}, 1);
    check(enc_uf == 0, "R12 underflow after reset", {31'd0, enc_uf}, 0);
    src_valid = 7'h7f;
    repeat (3) @(negedge clk);
    #1 check(src_ready == 0, "R12 no layers active", {25'd0, src_ready}, 0);
    src_valid = 0;
    reader_on = 1;

    // Set A: 3 layers, installed at once (R8)
    pa = '{3'd0, 3'd4, 3'd5, 3'd0, 3'd0};
    configure(7'b011_0001, pa, 24'h204060, 24'h0, 4'b0000, "R5 legal commit A");
    run_pixels(40, 0, 4000, got);
    check(got == 40, "R7 set A progress", got, 40);

    // Set B pending until frame start (R8)
    pb = '{3'd6, 3'd3, 3'd0, 3'd5, 3'd4};
    configure(7'b111_1001, pb, 24'hf0_80_10, 24'h0, 4'b0000, "R5 legal commit B");
    run_pixels(20, 0, 4000, got);
    check(got == 20, "R8 old set kept before marker", got, 20);
    run_pixels(40, 1, 4000, got);
    check(got == 40, "R8 set B after marker", got, 40);
    drain();

    // Illegal commits (R1..R4) leave set B in force (R5)
    px = '{3'd0, 3'd1, 3'd0, 3'd0, 3'd0};
    configure(7'b000_0011, px, 24'h0, 24'h0, 4'b0010, "R1 ineligible source");
    px = '{3'd4, 3'd4, 3'd0, 3'd0, 3'd0};
    configure(7'b011_0000, px, 24'h0, 24'h0, 4'b0001, "R2 duplicate priority");
    px = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
    configure(7'b111_1111, px, 24'h0, 24'h0, 4'b0110, "R3 over layer limit");
    px = '{3'd4, 3'd0, 3'd0, 3'd0, 3'd0};
    configure(7'b001_0000, px, 24'h0, 24'h00_1010, 4'b1000, "R4 interlaced graphics");
    run_pixels(20, 1, 4000, got);
    check(got == 20, "R5 set B still active", got, 20);
    drain();

    // Set C: single graphics layer, interlaced on progressive path is legal (R4)
    px = '{3'd6, 3'd0, 3'd0, 3'd0, 3'd0};
    configure(7'b100_0000, px, 24'h0a0b0c, 24'h00_0040, 4'b0000, "R4 progressive path legal");
    run_pixels(30, 1, 4000, got);
    drain();

    // Backpressure (R10)
    repeat (10) @(negedge enc_clk);
    reader_on = 0;
    repeat (4) @(negedge enc_clk);
    run_pixels(DEPTH + 8, 0, 300, got);
    check(got == DEPTH, "R10 accepted while encoder idle", got, DEPTH);
    drain();
    repeat (6) @(negedge enc_clk);

    // Underflow (R11)
    reader_on = 0;
    repeat (3) @(negedge enc_clk);
    check(enc_uf == 0, "R11 no underflow yet", {31'd0, enc_uf}, 0);
    check(enc_empty == 1, "R11 fifo empty", {31'd0, enc_empty}, 1);
    force_rd = 1;
    repeat (3) @(negedge enc_clk);
    check(enc_uf == 1, "R11 underflow set", {31'd0, enc_uf}, 1);
    reader_on = 1;
    run_pixels(10, 0, 2000, got);
    drain();
    check(enc_uf == 1, "R11 underflow sticky", {31'd0, enc_uf}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule